// File: doc/BRIEF.md
# Segmented Physical-Address Bus Cycle Unit

This block accepts one memory or I/O request at a time, described by a 16-bit segment, a 16-bit offset, a size (byte or word), a direction (read or write) and a space select (memory or I/O). It forms a 20-bit physical address by shifting the segment four places left and adding the offset, with the sum wrapping at 2^20. It then runs the bus cycles needed to move the data through a memory built from two byte-wide banks. One bank holds every even address and the other holds every odd address. Each bank has its own enable and its own byte lane on a 16-bit data path.

A word is stored low byte first, so a word at an even address moves in a single bus cycle over both lanes. A word at an odd address spans two bank rows and takes two cycles. The first cycle moves the low byte through the odd bank at the address itself. The second cycle moves the high byte through the even bank at the next address. A byte access enables only the bank that address bit 0 selects. When the last bus cycle of a request has finished, a one-cycle completion pulse follows, and read results appear on a registered output.

Control is one state machine. ST_IDLE waits for a request. The transition *accept* (request seen in ST_IDLE) captures the request and moves to ST_FIRST. ST_FIRST drives the first bus cycle. From ST_FIRST, *split* (an odd-address word) goes to ST_SECOND and *finish* (all other requests) goes to ST_FINISH. ST_SECOND drives the second bus cycle and then goes to ST_FINISH on *finish*. ST_FINISH raises the completion pulse for one cycle, and *retire* returns to ST_IDLE.

Top module: `seg_bank_bus`

## Requirements
- R1: In the first bus cycle, bus_addr equals ({req_seg, 4'h0} + req_off) modulo 2^20. For example, FFFF:FFFF gives 0FFEF.
- R2: A word request whose physical address has bit 0 = 0 uses exactly one bus cycle with bus_en_even = bus_en_odd = 1. The low byte travels on lane bits [7:0] and the high byte on lane bits [15:8]. A read returns {odd lane, even lane} on rd_data.
- R3: A byte request uses one bus cycle and enables only one bank: bus_en_even when address bit 0 is 0, and bus_en_odd when it is 1. The write byte is taken from req_wdata[7:0] and placed on that bank's lane ([7:0] for even, [15:8] for odd). A read returns the byte in rd_data[7:0] with rd_data[15:8] = 0.
- R4: A word request at an odd address uses exactly two bus cycles. The first cycle uses address A with only bus_en_odd set, carrying the low byte on [15:8]. The second cycle uses A+1 with only bus_en_even set, carrying the high byte on [7:0].
- R5: In the second cycle the address A+1 wraps modulo 2^20, so FFFFF is followed by 00000.
- R6: bus_rd is 1 during the bus cycles of a read and bus_wr is 1 during those of a write. The two are never 1 together. During a bus cycle, bus_io equals the request's req_io (0 = memory, 1 = I/O). The bank enables are 0 whenever neither strobe is 1.
- R7: done is 1 for exactly one cycle, in the cycle right after the last bus cycle of a request. rd_data holds its value from the last read until the next read completes; writes leave it unchanged.
- R8: req_valid is sampled only in ST_IDLE. A request presented while an access is in progress, including its completion cycle, starts no bus cycle and produces no done.
- R9: After reset, bus_rd, bus_wr, both bank enables and done are 0, and rd_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present (sampled in ST_IDLE) |
| req_seg | input | 16 | Segment value |
| req_off | input | 16 | Offset within segment |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_wdata | input | 16 | Write data (byte in [7:0]) |
| rd_data | output | 16 | Registered read result |
| done | output | 1 | One-cycle completion pulse |
| bus_addr | output | 20 | Physical address of the current bus cycle |
| bus_en_even | output | 1 | Even-bank enable |
| bus_en_odd | output | 1 | Odd-bank enable |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_io | output | 1 | Space select, 1 = I/O |
| bus_wdata | output | 16 | Write lanes: [7:0] even bank, [15:8] odd bank |
| bus_rdata | input | 16 | Read lanes: [7:0] even bank, [15:8] odd bank |

## Verification
The bench builds the unit with its default parameters: 16-bit segment and offset, a 4-bit shift, a 20-bit physical address and 8-bit bank lanes. With these values a segment and offset near FFFF push the sum past 2^20, so both the first-cycle wrap and the FFFFF-to-00000 step of a split word can be reached. A bank model that decodes the low ten address bits is enough to check data placement on both lanes in aligned, odd-aligned and byte accesses. It also lets the bench confirm that requests held during the busy states leave memory and the completion count untouched.

// File: rtl/sbb_pkg.sv
package sbb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_FINISH = 2'd3
    } sbb_state_e;
endpackage

// File: rtl/sbb_addr_gen.sv
module sbb_addr_gen #(
    parameter int SEG_W   = 16,
    parameter int OFF_W   = 16,
    parameter int SHIFT   = 4,
    parameter int PADDR_W = 20
) (
    input  logic [SEG_W-1:0]   seg,
    input  logic [OFF_W-1:0]   off,
    output logic [PADDR_W-1:0] phys
);
    localparam int BASE_W = SEG_W + SHIFT;

    logic [BASE_W-1:0]  base_full;
    logic [PADDR_W-1:0] base_t;
    logic [PADDR_W-1:0] off_t;

    always_comb begin
        base_full = {seg, {SHIFT{1'b0}}};
        base_t    = PADDR_W'(base_full);
        off_t     = PADDR_W'(off);
        phys      = base_t + off_t;
    end
endmodule

// File: rtl/sbb_lane_ctl.sv
module sbb_lane_ctl #(
    parameter int BYTE_W = 8
) (
    input  logic                  active,
    input  logic                  word,
    input  logic                  a0,
    input  logic                  second,
    input  logic [2*BYTE_W-1:0]   wdata,
    input  logic [2*BYTE_W-1:0]   rdata,
    output logic                  en_even,
    output logic                  en_odd,
    output logic [2*BYTE_W-1:0]   wlane,
    output logic [BYTE_W-1:0]     pick
);
    localparam int DATA_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] lo_b;
    logic [BYTE_W-1:0] hi_b;

    always_comb begin
        lo_b    = wdata[BYTE_W-1:0];
        hi_b    = wdata[DATA_W-1:BYTE_W];
        en_even = 1'b0;
        en_odd  = 1'b0;
        wlane   = '0;
        if (active) begin
            if (second) begin
                en_even = 1'b1;
                wlane   = {{BYTE_W{1'b0}}, hi_b};
            end else if (word && !a0) begin
                en_even = 1'b1;
                en_odd  = 1'b1;
                wlane   = wdata;
            end else if (a0) begin
                en_odd  = 1'b1;
                wlane   = {lo_b, {BYTE_W{1'b0}}};
            end else begin
                en_even = 1'b1;
                wlane   = {{BYTE_W{1'b0}}, lo_b};
            end
        end
        pick = en_odd ? rdata[DATA_W-1:BYTE_W] : rdata[BYTE_W-1:0];
    end
endmodule

// File: rtl/seg_bank_bus.sv
module seg_bank_bus
    import sbb_pkg::*;
#(
    parameter int SEG_W   = 16,
    parameter int OFF_W   = 16,
    parameter int SHIFT   = 4,
    parameter int PADDR_W = 20,
    parameter int BYTE_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [SEG_W-1:0]    req_seg,
    input  logic [OFF_W-1:0]    req_off,
    input  logic                req_word,
    input  logic                req_write,
    input  logic                req_io,
    input  logic [2*BYTE_W-1:0] req_wdata,
    output logic [2*BYTE_W-1:0] rd_data,
    output logic                done,
    output logic [PADDR_W-1:0]  bus_addr,
    output logic                bus_en_even,
    output logic                bus_en_odd,
    output logic                bus_rd,
    output logic                bus_wr,
    output logic                bus_io,
    output logic [2*BYTE_W-1:0] bus_wdata,
    input  logic [2*BYTE_W-1:0] bus_rdata
);
    localparam int DATA_W = 2 * BYTE_W;

    sbb_state_e          state, state_nx;
    logic [PADDR_W-1:0]  req_phys;
    logic [PADDR_W-1:0]  cap_addr;
    logic                cap_word, cap_write, cap_io;
    logic [DATA_W-1:0]   cap_wdata;
    logic [DATA_W-1:0]   rd_q;
    logic                active, second, split;
    logic [DATA_W-1:0]   wlane;
    logic [BYTE_W-1:0]   pick;
    logic                en_even_i, en_odd_i;

    sbb_addr_gen #(
        .SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .PADDR_W(PADDR_W)
    ) u_addr (
        .seg(req_seg), .off(req_off), .phys(req_phys)
    );

    sbb_lane_ctl #(.BYTE_W(BYTE_W)) u_lane (
        .active(active), .word(cap_word), .a0(cap_addr[0]), .second(second),
        .wdata(cap_wdata), .rdata(bus_rdata),
        .en_even(en_even_i), .en_odd(en_odd_i), .wlane(wlane), .pick(pick)
    );

    assign split = cap_word && cap_addr[0];

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_FIRST;
            ST_FIRST:  state_nx = split ? ST_SECOND : ST_FINISH;
            ST_SECOND: state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request capture, only in ST_IDLE
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr  <= '0;
            cap_word  <= 1'b0;
            cap_write <= 1'b0;
            cap_io    <= 1'b0;
            cap_wdata <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            cap_addr  <= req_phys;
            cap_word  <= req_word;
            cap_write <= req_write;
            cap_io    <= req_io;
            cap_wdata <= req_wdata;
        end
    end

    // read data assembly
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (!cap_write) begin
            if (state == ST_FIRST) begin
                if (cap_word && !cap_addr[0]) rd_q <= bus_rdata;
                else if (cap_word)            rd_q[BYTE_W-1:0] <= pick;
                else                          rd_q <= {{BYTE_W{1'b0}}, pick};
            end else if (state == ST_SECOND) begin
                rd_q[DATA_W-1:BYTE_W] <= pick;
            end
        end
    end

    // outputs
    always_comb begin
        active      = (state == ST_FIRST) || (state == ST_SECOND);
        second      = (state == ST_SECOND);
        bus_addr    = second ? (cap_addr + PADDR_W'(1)) : cap_addr;
        bus_rd      = active && !cap_write;
        bus_wr      = active && cap_write;
        bus_io      = active && cap_io;
        bus_en_even = en_even_i;
        bus_en_odd  = en_odd_i;
        bus_wdata   = (active && cap_write) ? wlane : '0;
        done        = (state == ST_FINISH);
        rd_data     = rd_q;
    end

    // R6
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    // R6
    en_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en_even || bus_en_odd) |-> (bus_rd || bus_wr));
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R5
    second_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIRST && split) |=>
            (bus_addr == PADDR_W'($past(bus_addr) + PADDR_W'(1))));
    // R3
    byte_one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && !cap_word) |->
            ($countones({bus_en_even, bus_en_odd}) == 1));
    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(cap_addr));
    // R4
    split_first_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIRST && split) |-> (bus_en_odd && !bus_en_even));
endmodule

// File: tb/seg_bank_bus_bench.sv
`timescale 1ns/1ps
module seg_bank_bus_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_seg = '0, req_off = '0, req_wdata = '0;
    logic        req_word = 1'b0, req_write = 1'b0, req_io = 1'b0;
    logic [15:0] rd_data, bus_wdata, bus_rdata;
    logic        done, bus_en_even, bus_en_odd, bus_rd, bus_wr, bus_io;
    logic [19:0] bus_addr;

    always #10 clk = ~clk;

    seg_bank_bus u_seg_bank_bus (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
        .req_off(req_off), .req_word(req_word), .req_write(req_write),
        .req_io(req_io), .req_wdata(req_wdata), .rd_data(rd_data), .done(done),
        .bus_addr(bus_addr), .bus_en_even(bus_en_even), .bus_en_odd(bus_en_odd),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_io(bus_io),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // bank model: low ten address bits decoded
    logic [7:0] mem  [0:1023];
    logic [7:0] smem [0:1023];
    initial for (int i = 0; i < 1024; i++) begin mem[i] = 8'h00; smem[i] = 8'h00; end

    assign bus_rdata = {mem[{bus_addr[9:1], 1'b1}], mem[{bus_addr[9:1], 1'b0}]};
    always @(posedge clk) begin
        if (bus_wr && bus_en_even) mem[{bus_addr[9:1], 1'b0}] <= bus_wdata[7:0];
        if (bus_wr && bus_en_odd)  mem[{bus_addr[9:1], 1'b1}] <= bus_wdata[15:8];
    end

    typedef struct {
        logic [15:0] data;
        bit          is_rd;
        logic [19:0] a1;
        logic [19:0] a2;
        logic [1:0]  en1;
        int          ncyc;
        bit          io;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   vec = 0, bad = 0, issued = 0, done_cnt = 0;

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] expv, input string what);
        vec++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // monitor
    int          mcyc = 0;
    logic [19:0] ma1, ma2;
    logic [1:0]  men1, men2;
    bit          mrd, mio, prev_strobe = 0, prev_done = 0;
    exp_t        e;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done) chk("R7", {31'd0, done}, 32'd0, "done width");
            if (bus_rd || bus_wr) begin
                if (mcyc == 0) begin
                    ma1 = bus_addr; men1 = {bus_en_odd, bus_en_even};
                    mrd = bus_rd;   mio = bus_io;
                end else begin
                    ma2 = bus_addr; men2 = {bus_en_odd, bus_en_even};
                end
                mcyc++;
            end else if (bus_en_even || bus_en_odd) begin
                chk("R6", {30'd0, bus_en_odd, bus_en_even}, 32'd0, "enable without strobe");
            end
            if (done) begin
                done_cnt++;
                chk("R7", {31'd0, prev_strobe}, 32'd1, "done after last cycle");
                if (q.size() == 0) begin
                    chk("R8", 32'd1, 32'd0, "unexpected done");
                end else begin
                    e = q.pop_front();
                    chk("R1", {12'd0, ma1}, {12'd0, e.a1}, "first address");
                    chk(e.tag, {30'd0, men1}, {30'd0, e.en1}, "first enables");
                    chk("R4", mcyc, e.ncyc, "bus cycle count");
                    chk("R6", {31'd0, mrd}, {31'd0, e.is_rd}, "read strobe");
                    chk("R6", {31'd0, mio}, {31'd0, e.io}, "io select");
                    if (e.ncyc == 2) begin
                        chk("R5", {12'd0, ma2}, {12'd0, e.a2}, "second address");
                        chk("R4", {30'd0, men2}, 32'd1, "second enables");
                    end
                    if (e.is_rd) chk(e.tag, {16'd0, rd_data}, {16'd0, e.data}, "read data");
                end
                mcyc = 0;
            end
            prev_strobe = bus_rd || bus_wr;
            prev_done   = done;
        end
    end

    // driver
    task automatic issue(input logic [15:0] seg, input logic [15:0] off,
                         input bit word, input bit wr, input bit io,
                         input logic [15:0] wd, input string tag, input bit junk);
        exp_t        x;
        logic [19:0] pa, pb;
        pa = {seg, 4'h0} + {4'h0, off};
        pb = pa + 20'd1;
        x.a1 = pa; x.a2 = pb;
        x.ncyc = (word && pa[0]) ? 2 : 1;
        x.en1 = word ? (pa[0] ? 2'b10 : 2'b11) : (pa[0] ? 2'b10 : 2'b01);
        x.is_rd = !wr; x.io = io; x.tag = tag; x.data = '0;
        if (!wr) begin
            x.data = word ? {smem[pb[9:0]], smem[pa[9:0]]} : {8'h00, smem[pa[9:0]]};
        end else begin
            smem[pa[9:0]] = wd[7:0];
            if (word) smem[pb[9:0]] = wd[15:8];
        end
        q.push_back(x);
        issued++;
        req_valid = 1'b1; req_seg = seg; req_off = off; req_word = word;
        req_write = wr;   req_io = io;   req_wdata = wd;
        @(negedge clk);
        if (junk) begin
            req_seg = ~seg; req_off = off + 16'h0101; req_write = !wr; req_wdata = ~wd;
            repeat (2) @(negedge clk);
        end
        req_valid = 1'b0;
        while (done_cnt < issued) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9", {28'd0, bus_rd, bus_wr, bus_en_even, bus_en_odd}, 32'd0, "strobes in reset");
        chk("R9", {31'd0, done}, 32'd0, "done in reset");
        chk("R9", {16'd0, rd_data}, 32'd0, "rd_data in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", {28'd0, bus_rd, bus_wr, bus_en_even, bus_en_odd}, 32'd0, "idle after reset");

        issue(16'h1234, 16'h0022, 1, 1, 0, 16'hBEEF, "R2", 0);
        issue(16'h1234, 16'h0022, 1, 0, 0, 16'h0000, "R2", 0);
        issue(16'h123A, 16'h341B, 0, 1, 0, 16'h775A, "R3", 0);
        chk("R7", {16'd0, rd_data}, {16'd0, 16'hBEEF}, "rd_data held over write");
        issue(16'h157B, 16'h000A, 0, 1, 0, 16'h993C, "R3", 0);
        issue(16'h157B, 16'h000A, 1, 0, 0, 16'h0000, "R2", 0);
        issue(16'h157B, 16'h000B, 0, 0, 0, 16'h0000, "R3", 0);
        issue(16'h157B, 16'h000B, 1, 1, 0, 16'h1234, "R4", 0);
        issue(16'h157B, 16'h000B, 1, 0, 0, 16'h0000, "R4", 0);
        issue(16'h157B, 16'h000C, 0, 0, 0, 16'h0000, "R3", 0);
        issue(16'hFFFF, 16'hFFFF, 1, 1, 0, 16'hC0DE, "R1", 0);
        issue(16'hFFFF, 16'hFFFF, 1, 0, 0, 16'h0000, "R1", 0);
        issue(16'hF000, 16'hFFFF, 1, 1, 0, 16'hA55A, "R5", 0);
        issue(16'hF000, 16'hFFFF, 1, 0, 0, 16'h0000, "R5", 0);
        issue(16'h0100, 16'h0004, 1, 1, 1, 16'h6B2D, "R6", 0);
        issue(16'h0100, 16'h0004, 1, 0, 1, 16'h0000, "R6", 0);
        issue(16'h1234, 16'h0022, 1, 0, 0, 16'h0000, "R8", 1);
        issue(16'hF000, 16'hFFFF, 1, 0, 0, 16'h0000, "R8", 1);
        issue(16'hEDCB, 16'hFFDD, 1, 0, 0, 16'h0000, "R8", 0);
        issue(16'h157B, 16'h000A, 1, 0, 0, 16'h0000, "R8", 0);
        repeat (4) @(negedge clk);
        chk("R8", done_cnt, issued, "completion count");
        chk("R8", q.size(), 32'd0, "pending expectations");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        vec++; bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule